// File: doc/BRIEF.md
# DDR Burst Column Address Sequencer

This block sits between a memory controller's command path and the column address pins of a DDR-style memory. It keeps a copy of the mode register and uses it to order the column addresses of every read or write burst. A mode-register-set command with both bank bits at zero loads four fields from the command address:

- the burst length code,
- the burst order (sequential or interleaved),
- the CAS latency code,
- the operating-mode field.

The write is accepted only while the controller reports every bank idle and no burst is running. A write attempted at any other time is refused and flagged.

A read or write command carries a starting column. The block then presents one column address per clock, with a valid strobe and a flag on the final beat. The addresses stay inside an aligned block whose size is the burst length and wrap around within it. The CAS latency code is only stored and shown on an output. Bit 8 of the operating mode clears itself one cycle after it is written.

Top module: `ddr_burst_seq`

## Requirements
- R1: After reset the stored mode is: length code 3'b001, sequential order, CAS code 3'b010, operating mode all zero. `beat_valid` and `mode_err` are low.
- R2: A set command with `cmd_ba` == 0, `banks_idle` high and no burst active loads the mode on that clock edge, with these field positions:
  - length code from `cmd_addr[2:0]`
  - order from `cmd_addr[3]` (1 = interleaved)
  - CAS code from `cmd_addr[6:4]`
  - operating mode from `cmd_addr[12:7]`
- R3: A set command with a nonzero `cmd_ba` changes no stored field and raises no error.
- R4: A set command with `cmd_ba` == 0 is refused in two cases: `banks_idle` is low, or a burst is active. A refused command leaves the mode unchanged and drives `mode_err` high for exactly the following cycle.
- R5: Stored operating-mode bit 8 (`mode_op[1]`) reads 1 for the single cycle after a write that set it. It then returns to 0, unless the next cycle performs another accepted write.
- R6: An accepted command gives exactly the number of beats in the burst: codes 001, 010 and 011 mean 2, 4 and 8 beats. The beats run on consecutive cycles, the first in the cycle after the command. `beat_last` is high on the final beat only.
- R7: In sequential order, beat i has low bits equal to (start low bits + i) modulo the length. The column bits above the block are those of the starting column on every beat.
- R8: In interleaved order, beat i has low bits equal to (start low bits XOR i). The upper bits are unchanged.
- R9: Any other length code (000 or 1xx) may be stored, but a command issued under it starts no burst.
- R10: A read or write command that arrives while a burst is active, including on its final beat, is ignored.
- R11: Reads and writes use the same length and order. The command direction appears on `beat_wr` for every beat of the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_mrs | input | 1 | Mode-register-set command strobe |
| cmd_ba | input | 2 | Bank address of the command |
| cmd_addr | input | 13 | Mode value carried by a set command |
| banks_idle | input | 1 | Controller reports all banks idle |
| cmd_rw | input | 1 | Read/write command strobe |
| cmd_wr | input | 1 | 1 = write, 0 = read |
| cmd_col | input | COL_W | Starting column address |
| beat_col | output | COL_W | Column address of the current beat |
| beat_valid | output | 1 | A beat is presented |
| beat_last | output | 1 | Final beat of the burst |
| beat_wr | output | 1 | Direction of the current burst |
| burst_busy | output | 1 | Burst in progress |
| mode_err | output | 1 | Refused mode write, one cycle |
| mode_bl | output | 3 | Stored length code |
| mode_ilv | output | 1 | Stored order, 1 = interleaved |
| mode_cas | output | 3 | Stored CAS latency code |
| mode_op | output | 6 | Stored operating mode (address bits 12:7) |

## Verification
The hardest situations to reach from the ports are collisions with a running burst. These are a mode write or a new command that lands exactly on the final beat, and an 8-beat burst whose start sits in the middle of its block so that the wrap is exercised. The stimulus issues mode writes and commands a fixed number of cycles after a burst starts, with that count chosen to hit the last beat. It uses starting columns with nonzero low bits and all-ones upper bits. A behavioural model rebuilds every beat from the block arithmetic and compares it on every cycle.

// File: rtl/ddr_burst_pkg.sv
package ddr_burst_pkg;

    localparam int MODE_W  = 13;
    localparam int LOW_W   = 3;

    localparam logic [2:0] BL_CODE_2   = 3'b001;
    localparam logic [2:0] BL_CODE_4   = 3'b010;
    localparam logic [2:0] BL_CODE_8   = 3'b011;
    localparam logic [2:0] CAS_DEFAULT = 3'b010;

    typedef struct packed {
        logic [5:0] op;
        logic [2:0] cas;
        logic       ilv;
        logic [2:0] bl;
    } mode_t;

    localparam mode_t MODE_RESET = '{op: 6'd0, cas: CAS_DEFAULT, ilv: 1'b0, bl: BL_CODE_2};

    function automatic logic bl_legal(input logic [2:0] code);
        return (code == BL_CODE_2) || (code == BL_CODE_4) || (code == BL_CODE_8);
    endfunction

    function automatic logic [LOW_W-1:0] bl_mask(input logic [2:0] code);
        case (code)
            BL_CODE_2: bl_mask = 3'b001;
            BL_CODE_4: bl_mask = 3'b011;
            default:   bl_mask = 3'b111;
        endcase
    endfunction

endpackage

// File: rtl/ddr_mode_reg.sv
module ddr_mode_reg
    import ddr_burst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mrs_i,
    input  logic [1:0]        ba_i,
    input  logic [MODE_W-1:0] addr_i,
    input  logic              banks_idle_i,
    input  logic              burst_busy_i,
    output mode_t             mode_o,
    output logic              err_o
);

    typedef struct packed {
        mode_t mode;
        logic  err;
    } st_t;

    st_t  st_d, st_q;
    logic sel;

    assign sel = mrs_i && (ba_i == 2'b00);

    always_comb begin
        st_d           = st_q;
        st_d.err       = 1'b0;
        st_d.mode.op[1] = 1'b0;
        if (sel) begin
            if (banks_idle_i && !burst_busy_i) begin
                st_d.mode = mode_t'(addr_i);
            end else begin
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_RESET, err: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o = st_q.mode;
    assign err_o  = st_q.err;

    // R4: an error pulse needs a refused set command one cycle earlier
    a_r4_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(mrs_i && ba_i == 2'b00 && (!banks_idle_i || burst_busy_i)));

    // R4: the stored length cannot change across a cycle with a burst active
    a_r4_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
        burst_busy_i |=> $stable(mode_o.bl));

    // R5: bit 8 drops after one cycle unless rewritten
    a_r5_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o.op[1] && !sel) |=> !mode_o.op[1]);

endmodule

// File: rtl/ddr_burst_gen.sv
module ddr_burst_gen
    import ddr_burst_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             wr_i,
    input  logic [COL_W-1:0] col_i,
    input  logic [2:0]       bl_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o,
    output logic             wr_o,
    output logic             busy_o
);

    typedef struct packed {
        logic             active;
        logic [LOW_W-1:0] beat;
        logic [LOW_W-1:0] mask;
        logic [COL_W-1:0] base;
        logic             ilv;
        logic             wr;
    } st_t;

    st_t              st_d, st_q;
    logic             at_end;
    logic [LOW_W-1:0] low_start, low_seq, low_cur;

    assign at_end = st_q.beat == st_q.mask;

    always_comb begin
        st_d = st_q;
        if (st_q.active) begin
            if (at_end) begin
                st_d.active = 1'b0;
            end else begin
                st_d.beat = st_q.beat + 1'b1;
            end
        end else if (start_i && bl_legal(bl_i)) begin
            st_d.active = 1'b1;
            st_d.beat   = '0;
            st_d.mask   = bl_mask(bl_i);
            st_d.base   = col_i;
            st_d.ilv    = ilv_i;
            st_d.wr     = wr_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign low_start = st_q.base[LOW_W-1:0];
    assign low_seq   = (low_start & ~st_q.mask) | ((low_start + st_q.beat) & st_q.mask);
    assign low_cur   = st_q.ilv ? (low_start ^ st_q.beat) : low_seq;

    for (genvar i = 0; i < COL_W; i++) begin : g_col
        if (i < LOW_W) begin : g_low
            assign col_o[i] = low_cur[i];
        end else begin : g_high
            assign col_o[i] = st_q.base[i];
        end
    end

    assign valid_o = st_q.active;
    assign last_o  = st_q.active && at_end;
    assign wr_o    = st_q.wr;
    assign busy_o  = st_q.active;

    // R6: the final beat is followed by an idle cycle
    a_r6_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> !valid_o);

    // R6: no gap inside a burst
    a_r6_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o) |=> valid_o);

    // R7: bits above the largest block never move within a burst
    a_r7_upper_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o) |=> $stable(col_o[COL_W-1:LOW_W]));

    // R11: direction held for the whole burst
    a_r11_wr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o) |=> $stable(wr_o));

endmodule

// File: rtl/ddr_burst_seq.sv
module ddr_burst_seq
    import ddr_burst_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_mrs,
    input  logic [1:0]       cmd_ba,
    input  logic [12:0]      cmd_addr,
    input  logic             banks_idle,
    input  logic             cmd_rw,
    input  logic             cmd_wr,
    input  logic [COL_W-1:0] cmd_col,
    output logic [COL_W-1:0] beat_col,
    output logic             beat_valid,
    output logic             beat_last,
    output logic             beat_wr,
    output logic             burst_busy,
    output logic             mode_err,
    output logic [2:0]       mode_bl,
    output logic             mode_ilv,
    output logic [2:0]       mode_cas,
    output logic [5:0]       mode_op
);

    mode_t mode;
    logic  busy;

    ddr_mode_reg u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .mrs_i       (cmd_mrs),
        .ba_i        (cmd_ba),
        .addr_i      (cmd_addr),
        .banks_idle_i(banks_idle),
        .burst_busy_i(busy),
        .mode_o      (mode),
        .err_o       (mode_err)
    );

    ddr_burst_gen #(.COL_W(COL_W)) u_gen (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(cmd_rw),
        .wr_i   (cmd_wr),
        .col_i  (cmd_col),
        .bl_i   (mode.bl),
        .ilv_i  (mode.ilv),
        .col_o  (beat_col),
        .valid_o(beat_valid),
        .last_o (beat_last),
        .wr_o   (beat_wr),
        .busy_o (busy)
    );

    assign burst_busy = busy;
    assign mode_bl    = mode.bl;
    assign mode_ilv   = mode.ilv;
    assign mode_cas   = mode.cas;
    assign mode_op    = mode.op;

    // R9: a burst only ever runs under a legal length code
    a_r9_legal_only: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(beat_valid)) |-> $past(bl_legal(mode.bl)));

endmodule

// File: tb/ddr_burst_seq_test.sv
module ddr_burst_seq_test;

    localparam int COL_W = 10;

    logic             clk = 0;
    logic             rst_n = 0;
    logic             cmd_mrs = 0;
    logic [1:0]       cmd_ba = 0;
    logic [12:0]      cmd_addr = 0;
    logic             banks_idle = 1;
    logic             cmd_rw = 0;
    logic             cmd_wr = 0;
    logic [COL_W-1:0] cmd_col = 0;
    logic [COL_W-1:0] beat_col;
    logic             beat_valid, beat_last, beat_wr, burst_busy, mode_err;
    logic [2:0]       mode_bl, mode_cas;
    logic             mode_ilv;
    logic [5:0]       mode_op;

    ddr_burst_seq #(.COL_W(COL_W)) uut (.*);

    always #2 clk = ~clk;

    int n_chk = 0, n_fail = 0, cycles = 0;

    // behavioural reference
    int   eq[$];
    int   ew[$];
    int   ei[$];
    int   m_bl = 1, m_ilv = 0, m_cas = 2, m_op = 0;
    int   e_err = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            eq.delete(); ew.delete(); ei.delete();
            m_bl = 1; m_ilv = 0; m_cas = 2; m_op = 0; e_err = 0;
        end else begin
            bit busy_b;
            busy_b = eq.size() > 0;
            if (busy_b) begin
                void'(eq.pop_front()); void'(ew.pop_front()); void'(ei.pop_front());
            end
            if (cmd_rw && !busy_b && (m_bl >= 1 && m_bl <= 3)) begin
                int n, s, blk;
                n   = 1 << m_bl;
                s   = int'(cmd_col) % n;
                blk = int'(cmd_col) - s;
                for (int i = 0; i < n; i++) begin
                    int off;
                    off = m_ilv ? (s ^ i) : ((s + i) % n);
                    eq.push_back(blk + off);
                    ew.push_back(int'(cmd_wr));
                    ei.push_back(m_ilv);
                end
            end
            e_err = 0;
            m_op  = m_op & ~2;
            if (cmd_mrs && cmd_ba == 0) begin
                if (banks_idle && !busy_b) begin
                    m_bl  = int'(cmd_addr[2:0]);
                    m_ilv = int'(cmd_addr[3]);
                    m_cas = int'(cmd_addr[6:4]);
                    m_op  = int'(cmd_addr[12:7]);
                end else begin
                    e_err = 1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            int ev;
            ev = eq.size() > 0;
            check(beat_valid == ev, "R6 valid", beat_valid, ev);
            check(beat_last == (eq.size() == 1), "R6 last", beat_last, eq.size() == 1);
            if (ev && beat_valid) begin
                check(int'(beat_col) == eq[0], ei[0] ? "R8 column" : "R7 column", beat_col, eq[0]);
                check(int'(beat_wr) == ew[0], "R11 direction", beat_wr, ew[0]);
            end
            check(int'(mode_bl) == m_bl && int'(mode_ilv) == m_ilv && int'(mode_cas) == m_cas,
                  "R2 mode fields", {mode_bl, mode_ilv, mode_cas}, (m_bl << 4) | (m_ilv << 3) | m_cas);
            check(int'(mode_op) == m_op, "R5 op field", mode_op, m_op);
            check(int'(mode_err) == e_err, "R4 error", mode_err, e_err);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic mrs(input logic [1:0] ba, input logic [12:0] val, input logic idle);
        @(negedge clk);
        cmd_mrs = 1; cmd_ba = ba; cmd_addr = val; banks_idle = idle;
        @(negedge clk);
        cmd_mrs = 0; cmd_ba = 0; banks_idle = 1;
    endtask

    task automatic rw(input logic wr, input int col);
        @(negedge clk);
        cmd_rw = 1; cmd_wr = wr; cmd_col = COL_W'(col);
        @(negedge clk);
        cmd_rw = 0;
    endtask

    function automatic logic [12:0] mval(input int op, input int cas, input int ilv, input int bl);
        return {6'(op), 3'(cas), 1'(ilv), 3'(bl)};
    endfunction

    initial begin
        tick(4);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(mode_bl == 3'b001 && mode_ilv == 0 && mode_cas == 3'b010 && mode_op == 0,
              "R1 reset mode", {mode_bl, mode_ilv, mode_cas}, 8'b0010_010);
        check(!beat_valid && !mode_err, "R1 reset outputs", {beat_valid, mode_err}, 0);

        rw(0, 5);   tick(3);               // BL2 seq, start mid-block
        rw(1, 10'h3FF); tick(3);
        mrs(2'b00, mval(0, 3, 0, 2), 1);   // BL4 sequential
        rw(0, 10'h1E); tick(5);
        rw(1, 10'h3F7); tick(5);
        mrs(2'b00, mval(2, 5, 1, 3), 1);   // BL8 interleaved, bit 8 set
        // R5: bit 8 visible in first cycle after write, cleared in second
        check(mode_op == 6'd2, "R5 bit8 set", mode_op, 2);
        @(negedge clk);
        check(mode_op == 6'd0, "R5 bit8 cleared", mode_op, 0);
        rw(1, 10'h3FD); tick(9);
        rw(0, 10'h0A); tick(9);
        mrs(2'b00, mval(0, 3, 0, 3), 1);   // BL8 sequential
        rw(0, 10'h0D); tick(9);
        mrs(2'b00, mval(0, 3, 1, 2), 1);   // BL4 interleaved
        rw(1, 10'h2B); tick(5);

        // R3: nonzero bank bits ignored
        mrs(2'b01, mval(1, 6, 0, 1), 1);
        check(mode_bl == 3'b010 && mode_ilv == 1 && !mode_err, "R3 ignored", mode_bl, 2);
        mrs(2'b10, mval(1, 6, 0, 3), 1);
        check(mode_bl == 3'b010 && mode_cas == 3'b011, "R3 ignored", mode_cas, 3);

        // R4: refused while banks active
        mrs(2'b00, mval(0, 2, 0, 1), 0);
        check(mode_err == 1 && mode_bl == 3'b010, "R4 banks active", mode_err, 1);

        // R4 + R10: set and new command on the final beat of a BL4 burst
        rw(0, 10'h31);                      // beats in next 4 cycles
        tick(2);
        @(negedge clk);
        cmd_mrs = 1; cmd_addr = mval(0, 2, 0, 1); cmd_rw = 1; cmd_col = 10'h100;
        check(beat_last == 1, "R10 on last beat", beat_last, 1);
        @(negedge clk);
        cmd_mrs = 0; cmd_rw = 0;
        check(mode_err == 1 && beat_valid == 0, "R10 ignored on last beat", beat_valid, 0);
        tick(2);

        // R9: reserved length codes start nothing
        mrs(2'b00, mval(0, 3, 0, 7), 1);
        rw(0, 10'h44);
        check(beat_valid == 0, "R9 reserved 111", beat_valid, 0);
        tick(2);
        mrs(2'b00, mval(0, 3, 0, 0), 1);
        rw(1, 10'h45);
        check(beat_valid == 0, "R9 reserved 000", beat_valid, 0);
        tick(2);

        // back-to-back after idle gap, BL2 interleaved
        mrs(2'b00, mval(0, 2, 1, 1), 1);
        rw(0, 10'h3FE); tick(2);
        rw(1, 10'h101); tick(4);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule